// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset requests into one internal active-low reset for a register file and the host port in front of it. The requests are an active-low reset pin, a power-on request from supply supervision, and a software reset raised by a host write to a dedicated register address. The pin and the power-on request act alike. Either one drives the internal reset low at once, without waiting for a clock edge, and the reset is released in step with the clock.

The software reset register is qualified by the host bus mode. On the two-wire bus (`bus_is_spi` low) any value written to that address starts a reset. On the four-wire bus (`bus_is_spi` high) only the 16-bit value 0x6600 does, and any other value is discarded. A software reset gives a single-cycle internal reset pulse.

After any reset the block holds a busy flag for a hold-off of `HOLD_US` microseconds, counted in cycles of a `CLK_MHZ` clock. While busy is high, host writes are dropped and reads return zero. The register file sits behind the `rf_*` port and sees only the host traffic that is accepted.

Top module: `rst_sequencer`

## Requirements
- R1: When `hw_rst_n` is low or `por_req` is high, `rst_int_n` goes low and `busy` goes high at once, with no clock edge needed, and both stay so while the request lasts.
- R2: After the last reset request is removed, `rst_int_n` rises on the `SYNC_STAGES`-th (default 2) rising clock edge.
- R3: After `rst_int_n` rises following a pin or power-on reset, `busy` stays high for exactly `CLK_MHZ*HOLD_US` cycles (7500 by default) and then falls.
- R4: While `busy` is high, `rf_wr_en` and `rf_rd_en` are low and `host_rdata` is zero.
- R5: While `busy` is low, a host read gives `rf_rd_en` high and `host_rdata` equal to `rf_rdata`. A host write to any address other than the software reset address gives `rf_wr_en` high with `rf_addr` and `rf_wdata` equal to the host values.
- R6: With `bus_is_spi` low, a host write of any value to address `SWRST_ADDR` (default 0x7C) while idle drives `rst_int_n` low for exactly the one cycle that follows the clock edge on which the write is taken.
- R7: With `bus_is_spi` high, only a write of 0x6600 to `SWRST_ADDR` starts a software reset. Any other value leaves `rst_int_n` high and `busy` low.
- R8: A software reset holds `busy` high for `CLK_MHZ*HOLD_US + 1` cycles, starting from the edge on which the write is taken: the pulse cycle plus the hold-off.
- R9: A write to `SWRST_ADDR` is never forwarded to the register file.
- R10: A write to `SWRST_ADDR` while `busy` is high is ignored. It neither pulses the reset nor restarts the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `CLK_MHZ` MHz |
| hw_rst_n | input | 1 | Asynchronous active-low reset pin |
| por_req | input | 1 | Power-on reset request, active high |
| bus_is_spi | input | 1 | Host bus mode: 1 = four-wire serial, 0 = two-wire serial |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data to the host, zero while busy |
| rf_wr_en | output | 1 | Accepted write to the register file |
| rf_rd_en | output | 1 | Accepted read from the register file |
| rf_addr | output | ADDR_W | Register file address |
| rf_wdata | output | DATA_W | Register file write data |
| rf_rdata | input | DATA_W | Register file read data |
| rst_int_n | output | 1 | Internal active-low reset |
| busy | output | 1 | High while reset or hold-off is in progress |

## Verification
The checker tests these properties on every cycle: a low internal reset always comes with busy high, host access stays gated while busy, the software pulse lasts one cycle and only follows a qualified write taken while idle, busy never falls before a full hold-off window, and the software reset address never reaches the register file. Some behaviours can only be shown by the bench's scenarios, because a property cannot observe them. These are the asynchronous assertion of the reset between clock edges, the exact edge on which the reset is released, the exact length of the hold-off for each reset source, and the fact that rejected keys and writes made while busy leave the block's behaviour unchanged.

// File: rtl/rstseq_pkg.sv
// Package: shared constants, bus mode type and hold-off arithmetic for the
// reset sequencer. Assumes the clock frequency is a whole number of MHz.
package rstseq_pkg;

    // Value the four-wire host must write to request a software reset.
    localparam logic [15:0] SPI_RESET_KEY = 16'h6600;

    // Host bus mode as seen by the software reset qualifier.
    typedef enum logic {
        BUS_TWO_WIRE  = 1'b0,
        BUS_FOUR_WIRE = 1'b1
    } bus_mode_e;

    // Number of clock cycles in a hold-off of hold_us microseconds.
    function automatic int unsigned hold_cycles(input int unsigned clk_mhz,
                                                input int unsigned hold_us);
        return clk_mhz * hold_us;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Module: reset request synchronizer. The raw active-low request clears
// every stage at once (asynchronous assertion). Ones are shifted in on the
// clock, so the output is released STAGES edges after the request goes away.
// Assumes STAGES >= 1.
module rstseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic raw_n,
    output logic sync_n
);

    generate
        if (STAGES == 1) begin : g_single
            logic q;
            // Single stage: clear asynchronously, set on the next edge.
            always_ff @(posedge clk or negedge raw_n) begin
                if (!raw_n) q <= 1'b0;
                else        q <= 1'b1;
            end
            assign sync_n = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            // Shift chain: clear asynchronously, fill with ones synchronously.
            always_ff @(posedge clk or negedge raw_n) begin
                if (!raw_n) q <= '0;
                else        q <= {q[STAGES-2:0], 1'b1};
            end
            assign sync_n = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rstseq_swkey.sv
// Module: software reset qualifier. It takes a host write to the reset
// address while idle and checks its data against the bus mode rule. On a
// match it raises a one-cycle pulse. Assumes busy covers the pulse cycle, so
// back-to-back pulses cannot happen. Synchronous active-low reset from the
// synchronized request.
module rstseq_swkey
    import rstseq_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 7,
    parameter int unsigned        DATA_W     = 16,
    parameter logic [ADDR_W-1:0]  SWRST_ADDR = 7'h7C
) (
    input  logic              clk,
    input  logic              sync_n,
    input  logic              busy,
    input  logic              bus_is_spi,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sw_pulse
);

    localparam logic [DATA_W-1:0] KEY = DATA_W'(SPI_RESET_KEY);

    bus_mode_e mode;
    logic      hit;
    logic      key_ok;

    // Decode mode, address hit and key match for the current host cycle.
    always_comb begin
        mode   = bus_mode_e'(bus_is_spi);
        hit    = wr_en && !busy && (addr == SWRST_ADDR);
        key_ok = (mode == BUS_TWO_WIRE) || (wdata == KEY);
    end

    // Register the qualified request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!sync_n) sw_pulse <= 1'b0;
        else         sw_pulse <= hit && key_ok;
    end

endmodule

// File: rtl/rstseq_holdoff.sv
// Module: hold-off timer. It reloads while the synchronized reset is active
// or a software pulse is present, then counts down to zero. Busy covers the
// reset, the pulse and the count. Synchronous active-low reset from the
// synchronized request.
module rstseq_holdoff #(
    parameter int unsigned HOLD_CYCLES = 7500
) (
    input  logic clk,
    input  logic sync_n,
    input  logic sw_pulse,
    output logic busy
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Reload on any reset event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!sync_n)           cnt <= LOAD;
        else if (sw_pulse)     cnt <= LOAD;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Busy during reset, during the software pulse and while counting.
    always_comb begin
        busy = !sync_n || sw_pulse || (cnt != '0);
    end

endmodule

// File: rtl/rstseq_gate.sv
// Module: host access gate. It passes host reads and writes to the register
// file only while idle and zeroes read data while busy. Writes to the
// software reset address stay inside the sequencer. Purely combinational.
module rstseq_gate #(
    parameter int unsigned        ADDR_W     = 7,
    parameter int unsigned        DATA_W     = 16,
    parameter logic [ADDR_W-1:0]  SWRST_ADDR = 7'h7C
) (
    input  logic              busy,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rf_wr_en,
    output logic              rf_rd_en,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);

    // Qualify strobes with busy and return zero data when blocked.
    always_comb begin
        rf_addr    = host_addr;
        rf_wdata   = host_wdata;
        rf_wr_en   = host_wr_en && !busy && (host_addr != SWRST_ADDR);
        rf_rd_en   = host_rd_en && !busy;
        host_rdata = busy ? '0 : rf_rdata;
    end

endmodule

// File: rtl/rst_sequencer.sv
// Module: multi-source reset sequencer top. It merges the pin and power-on
// requests into one synchronized reset and adds the software reset pulse.
// A hold-off timer gates host access after every reset. Assumes
// CLK_MHZ*HOLD_US fits a counter and that the host strobes are synchronous
// to clk.
module rst_sequencer #(
    parameter int unsigned                CLK_MHZ     = 250,
    parameter int unsigned                HOLD_US     = 30,
    parameter int unsigned                SYNC_STAGES = 2,
    parameter int unsigned                ADDR_W      = 7,
    parameter int unsigned                DATA_W      = 16,
    parameter logic [ADDR_W-1:0]          SWRST_ADDR  = 7'h7C
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              por_req,
    input  logic              bus_is_spi,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rf_wr_en,
    output logic              rf_rd_en,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rst_int_n,
    output logic              busy
);

    localparam int unsigned HOLD_CYCLES = rstseq_pkg::hold_cycles(CLK_MHZ, HOLD_US);

    logic raw_n;
    logic sync_n;
    logic sw_pulse;

    // Combine pin and power-on request into one raw active-low request.
    always_comb begin
        raw_n = hw_rst_n && !por_req;
    end

    rstseq_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .raw_n  (raw_n),
        .sync_n (sync_n)
    );

    rstseq_swkey #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SWRST_ADDR (SWRST_ADDR)
    ) u_swkey (
        .clk        (clk),
        .sync_n     (sync_n),
        .busy       (busy),
        .bus_is_spi (bus_is_spi),
        .wr_en      (host_wr_en),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .sw_pulse   (sw_pulse)
    );

    rstseq_holdoff #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_holdoff (
        .clk      (clk),
        .sync_n   (sync_n),
        .sw_pulse (sw_pulse),
        .busy     (busy)
    );

    rstseq_gate #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SWRST_ADDR (SWRST_ADDR)
    ) u_gate (
        .busy       (busy),
        .host_wr_en (host_wr_en),
        .host_rd_en (host_rd_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rf_wr_en   (rf_wr_en),
        .rf_rd_en   (rf_rd_en),
        .rf_addr    (rf_addr),
        .rf_wdata   (rf_wdata),
        .rf_rdata   (rf_rdata)
    );

    // Internal reset: synchronized request or software pulse.
    always_comb begin
        rst_int_n = sync_n && !sw_pulse;
    end

endmodule

// File: rtl/rst_sequencer_chk.sv
// Module: property checker for rst_sequencer, attached by bind. It watches
// the ports plus the synchronized reset. A run counter measures each busy
// window so that no long $past depth is needed.
module rst_sequencer_chk #(
    parameter int unsigned        HOLD_CYCLES = 7500,
    parameter int unsigned        ADDR_W      = 7,
    parameter int unsigned        DATA_W      = 16,
    parameter logic [ADDR_W-1:0]  SWRST_ADDR  = 7'h7C
) (
    input logic              clk,
    input logic              hw_rst_n,
    input logic              por_req,
    input logic              sync_n,
    input logic              bus_is_spi,
    input logic              host_wr_en,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              rf_wr_en,
    input logic              rf_rd_en,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              rst_int_n,
    input logic              busy
);

    localparam int unsigned RUN_W = $clog2(HOLD_CYCLES + 2);
    localparam logic [DATA_W-1:0] KEY = DATA_W'(rstseq_pkg::SPI_RESET_KEY);

    logic [RUN_W-1:0] run;

    // Count busy cycles since the synchronized reset was released.
    always_ff @(posedge clk) begin
        if (!busy || !sync_n)              run <= '0;
        else if (run < RUN_W'(HOLD_CYCLES)) run <= run + 1'b1;
    end

    // R1: a low internal reset always comes with busy.
    a_r1_reset_busy: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        !rst_int_n |-> busy);

    // R4: host access is gated while busy.
    a_r4_host_blocked: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        busy |-> (!rf_wr_en && !rf_rd_en && host_rdata == '0));

    // R6: the software pulse lasts a single cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        (sync_n && !rst_int_n) |=> rst_int_n);

    // R7: a software pulse follows only a qualified write taken while idle.
    a_r7_key_qualified: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        (sync_n && $fell(rst_int_n)) |->
            $past(host_wr_en && !busy && host_addr == SWRST_ADDR &&
                  (!bus_is_spi || host_wdata == KEY)));

    // R3: busy never falls before a full hold-off window.
    a_r3_hold_window: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        $fell(busy) |-> (run >= RUN_W'(HOLD_CYCLES)));

    // R9: the software reset address never reaches the register file.
    a_r9_no_forward: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        rf_wr_en |-> (rf_addr != SWRST_ADDR));

    // R10: a reset-address write while busy does not pulse the reset.
    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!hw_rst_n || por_req)
        (busy && rst_int_n && sync_n && host_wr_en && host_addr == SWRST_ADDR) |=> rst_int_n);

endmodule

bind rst_sequencer rst_sequencer_chk #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SWRST_ADDR  (SWRST_ADDR)
) u_chk (
    .clk        (clk),
    .hw_rst_n   (hw_rst_n),
    .por_req    (por_req),
    .sync_n     (sync_n),
    .bus_is_spi (bus_is_spi),
    .host_wr_en (host_wr_en),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rf_wr_en   (rf_wr_en),
    .rf_rd_en   (rf_rd_en),
    .rf_addr    (rf_addr),
    .rst_int_n  (rst_int_n),
    .busy       (busy)
);

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/100ps
// Directed bench for rst_sequencer: one task per scenario, each checking
// its own results against values derived from the requirements.
module rst_sequencer_tb;

    localparam int unsigned HOLD   = 30 * 250;
    localparam logic [6:0]  SWRST  = 7'h7C;
    localparam logic [15:0] RDPAT  = 16'hBEEF;

    logic        clk = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic        por_req = 1'b0;
    logic        bus_is_spi = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rf_wr_en;
    logic        rf_rd_en;
    logic [6:0]  rf_addr;
    logic [15:0] rf_wdata;
    logic [15:0] rf_rdata = RDPAT;
    logic        rst_int_n;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rst_sequencer u_dut (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .por_req    (por_req),
        .bus_is_spi (bus_is_spi),
        .host_wr_en (host_wr_en),
        .host_rd_en (host_rd_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rf_wr_en   (rf_wr_en),
        .rf_rd_en   (rf_rd_en),
        .rf_addr    (rf_addr),
        .rf_wdata   (rf_wdata),
        .rf_rdata   (rf_rdata),
        .rst_int_n  (rst_int_n),
        .busy       (busy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Count busy samples after the current one, ending at the first idle sample.
    task automatic count_busy(inout int n);
        for (int i = 0; i < HOLD + 50; i++) begin
            @(posedge clk); #1;
            if (!busy) break;
            n++;
        end
    endtask

    // Drive a one-cycle write at the negedge; returns 1 ns after the edge.
    task automatic host_write(input logic spi, input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_is_spi = spi; host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(posedge clk); #1;
        host_wr_en = 1'b0;
    endtask

    // Release the reset request and check the release edge and hold-off.
    task automatic release_and_hold(input string tag);
        int n;
        @(negedge clk);
        hw_rst_n = 1'b1; por_req = 1'b0;
        @(posedge clk); #1;
        check("R2", {tag, " still low after first edge"}, rst_int_n, 1'b0);
        @(posedge clk); #1;
        check("R2", {tag, " released on second edge"}, rst_int_n, 1'b1);
        n = busy ? 1 : 0;
        count_busy(n);
        check("R3", {tag, " hold-off length"}, n, HOLD);
    endtask

    task automatic t_reset_state();
        #1 hw_rst_n = 1'b0;
        #0.5;
        check("R1", "async reset before any edge", rst_int_n, 1'b0);
        check("R1", "busy before any edge", busy, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        host_wr_en = 1'b1; host_rd_en = 1'b1; host_addr = 7'h05;
        #0.5;
        check("R4", "write blocked in reset", rf_wr_en, 1'b0);
        check("R4", "read blocked in reset", rf_rd_en, 1'b0);
        check("R4", "read data zero in reset", host_rdata, 16'h0);
        host_wr_en = 1'b0; host_rd_en = 1'b0;
    endtask

    task automatic t_release();
        release_and_hold("pin");
    endtask

    task automatic t_passthrough();
        @(negedge clk);
        host_wr_en = 1'b1; host_rd_en = 1'b1; host_addr = 7'h12; host_wdata = 16'hA55A;
        #0.5;
        check("R5", "write forwarded", rf_wr_en, 1'b1);
        check("R5", "write data", rf_wdata, 16'hA55A);
        check("R5", "address", rf_addr, 7'h12);
        check("R5", "read forwarded", rf_rd_en, 1'b1);
        check("R5", "read data", host_rdata, RDPAT);
        host_addr = SWRST; bus_is_spi = 1'b1; host_wdata = 16'h1111;
        #0.5;
        check("R9", "reset address not forwarded", rf_wr_en, 1'b0);
        host_wr_en = 1'b0; host_rd_en = 1'b0;
    endtask

    task automatic t_spi_bad_keys();
        logic [15:0] bad [3] = '{16'h6601, 16'h0066, 16'h0000};
        foreach (bad[i]) begin
            host_write(1'b1, SWRST, bad[i]);
            check("R7", "bad key no reset", rst_int_n, 1'b1);
            check("R7", "bad key no busy", busy, 1'b0);
        end
    endtask

    task automatic t_sw_reset(input logic spi, input logic [15:0] d, input string req);
        int n;
        host_write(spi, SWRST, d);
        check(req, "pulse low after write edge", rst_int_n, 1'b0);
        n = busy ? 1 : 0;
        @(posedge clk); #1;
        check("R6", "pulse lasts one cycle", rst_int_n, 1'b1);
        if (busy) n++;
        count_busy(n);
        check("R8", "software hold-off length", n, HOLD + 1);
    endtask

    task automatic t_busy_block();
        int n;
        host_write(1'b0, SWRST, 16'h0001);
        n = busy ? 1 : 0;
        repeat (10) begin @(posedge clk); #1; if (busy) n++; end
        @(negedge clk);
        host_wr_en = 1'b1; host_rd_en = 1'b1; host_addr = 7'h20; host_wdata = 16'h7777;
        #0.5;
        check("R4", "write blocked in hold-off", rf_wr_en, 1'b0);
        check("R4", "read blocked in hold-off", rf_rd_en, 1'b0);
        check("R4", "read zero in hold-off", host_rdata, 16'h0);
        host_addr = SWRST;
        @(posedge clk); #1;
        if (busy) n++;
        host_wr_en = 1'b0; host_rd_en = 1'b0;
        check("R10", "busy write gives no pulse", rst_int_n, 1'b1);
        count_busy(n);
        check("R10", "hold-off not restarted", n, HOLD + 1);
    endtask

    task automatic t_hw_in_hold();
        host_write(1'b0, SWRST, 16'hFFFF);
        repeat (20) @(posedge clk);
        @(negedge clk); #0.5;
        hw_rst_n = 1'b0;
        #0.5;
        check("R1", "pin reset mid hold-off is immediate", rst_int_n, 1'b0);
        repeat (3) @(posedge clk);
        release_and_hold("pin after sw");
    endtask

    task automatic t_por();
        @(negedge clk); #0.5;
        por_req = 1'b1;
        #0.5;
        check("R1", "power-on request immediate", rst_int_n, 1'b0);
        check("R1", "power-on busy", busy, 1'b1);
        repeat (4) @(posedge clk);
        release_and_hold("por");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_release();
        t_passthrough();
        t_spi_bad_keys();
        t_sw_reset(1'b0, 16'h1234, "R6");
        t_sw_reset(1'b1, 16'h6600, "R7");
        t_busy_block();
        t_hw_in_hold();
        t_por();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule